// File: doc/BRIEF.md
# Host Command Mailbox

This block sits between a host processor and a secure coprocessor. The host fills a bank of sixteen 32-bit argument words through a simple word-addressed register bus. It then writes a command word. That write copies the command and the current argument words into a four-entry first-in-first-out queue as one transaction. Because of this, the host may start preparing the next request at once.

The coprocessor side sees the oldest queued transaction on a flat output port and removes it with a pop strobe. When it finishes a request, it presents a return code and sixteen result words together with a done strobe. The block captures those values into host-readable registers and then flags completion.

Three event sources share one interrupt line:
- completion,
- the queue becoming full,
- a command dropped because the queue was already full.

Each source has a sticky cause bit that is cleared by writing a one to it, and a mask bit in which a 1 disables the source.

Top module: `cmd_mailbox_top`

## Requirements
- R1: After reset the queue status word reads 0x100 (ready bit 8 set, count in bits 2:0 equal to 0), the cause word reads 0, the mask word reads 0xFFFFFFFF, `irq` is low and `cp_cmd_valid` is low.
- R2: Argument word i is read and written at byte offset 4*i, for i from 0 to 15, and reads back the last value written.
- R3: A write to offset 0x40 enqueues the written command word together with a snapshot of all sixteen argument words, and increments the count in bits 2:0 of offset 0xC4. Later argument writes do not change entries already queued.
- R4: A write to offset 0x40 while the count is 4 is dropped: the count stays 4 and cause bit 17 is set. The full check uses the count before that cycle's pop.
- R5: Cause bit 18 is set in the cycle the count reaches 4.
- R6: A `cp_done` pulse makes `cp_ret` readable at 0x80 and result word j readable at 0x84+4*j one clock later. Cause bit 0 is set one clock after that.
- R7: A write to the cause word at 0xC8 clears exactly the bits written as 1. A set event in the same cycle wins over the clear.
- R8: `irq` is high exactly when some cause bit is set whose bit in the mask word at 0xCC is 0. The mask word is fully writable.
- R9: Writes to 0x80 through 0xC4 have no effect. Offsets 0xD0 and above, and the command offset, read as zero.
- R10: `cp_cmd_valid` is high when the count is nonzero, and `cp_cmd` and `cp_params` show the oldest entry. A `cp_pop` with an empty queue is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Host byte address, word aligned |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Host read data for `bus_addr`, combinational |
| cp_cmd_valid | output | 1 | Queue holds at least one transaction |
| cp_cmd | output | DATA_W | Command word of the oldest transaction |
| cp_params | output | NUM_WORDS*DATA_W | Argument snapshot of the oldest transaction, word i in bits [32*i+31:32*i] |
| cp_pop | input | 1 | Remove the oldest transaction |
| cp_ret | input | DATA_W | Return code posted by the coprocessor |
| cp_results | input | NUM_WORDS*DATA_W | Result words posted by the coprocessor |
| cp_done | input | 1 | Strobe capturing `cp_ret` and `cp_results` |
| irq | output | 1 | Interrupt, OR of the unmasked cause bits |

## Verification
The assertions watch these relations on every cycle:
- The queue count never exceeds its depth.
- A command write into a full queue always raises the drop cause.
- Reaching the depth always raises the full cause.
- A done strobe is followed two clocks later by the completion cause.
- A fully set mask, or an empty cause word, always keeps the interrupt low.
- A pop on an empty queue leaves the count alone.

Only the bench scenarios can show the data contents:
- the argument snapshot being frozen at enqueue time,
- first-in-first-out order across pointer wrap,
- the exact values captured in the result registers,
- bits surviving a write-one-to-clear with zeros,
- writes to read-only offsets leaving state unchanged.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;

  localparam int READY_BIT      = 8;
  localparam int CAUSE_DONE_BIT = 0;
  localparam int CAUSE_DROP_BIT = 17;
  localparam int CAUSE_FULL_BIT = 18;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_PARAM,
    REG_CMD,
    REG_RET,
    REG_RES,
    REG_QSTAT,
    REG_CAUSE,
    REG_MASK
  } mbx_reg_e;

endpackage

// File: rtl/mbx_addr_decode.sv
module mbx_addr_decode
  import cmd_mailbox_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 16,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output mbx_reg_e          region,
  output logic [IDX_W-1:0]  sub_idx
);

  localparam int WIDX_W   = ADDR_W - 2;
  localparam int CMD_WI   = NUM_WORDS;
  localparam int RET_WI   = 2 * NUM_WORDS;
  localparam int RES_WI   = RET_WI + 1;
  localparam int QSTAT_WI = RES_WI + NUM_WORDS;
  localparam int CAUSE_WI = QSTAT_WI + 1;
  localparam int MASK_WI  = CAUSE_WI + 1;

  logic [WIDX_W-1:0] widx;
  int                wi;

  assign widx = addr[ADDR_W-1:2];

  always_comb begin
    wi      = int'(widx);
    region  = REG_NONE;
    sub_idx = '0;
    if (wi < NUM_WORDS) begin
      region  = REG_PARAM;
      sub_idx = IDX_W'(wi);
    end else if (wi == CMD_WI) begin
      region = REG_CMD;
    end else if (wi == RET_WI) begin
      region = REG_RET;
    end else if ((wi >= RES_WI) && (wi < QSTAT_WI)) begin
      region  = REG_RES;
      sub_idx = IDX_W'(wi - RES_WI);
    end else if (wi == QSTAT_WI) begin
      region = REG_QSTAT;
    end else if (wi == CAUSE_WI) begin
      region = REG_CAUSE;
    end else if (wi == MASK_WI) begin
      region = REG_MASK;
    end
  end

endmodule

// File: rtl/mbx_word_bank.sv
module mbx_word_bank #(
  parameter int NUM_WORDS = 16,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        load_en,
  input  logic [NUM_WORDS*DATA_W-1:0] load_data,
  output logic [NUM_WORDS*DATA_W-1:0] words
);

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic              w_en;
    logic [DATA_W-1:0] w_nxt;
    logic [DATA_W-1:0] w_q;

    always_comb begin
      w_en  = 1'b0;
      w_nxt = w_q;
      if (load_en) begin
        w_en  = 1'b1;
        w_nxt = load_data[g*DATA_W +: DATA_W];
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        w_en  = 1'b1;
        w_nxt = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w_q <= '0;
      end else if (w_en) begin
        w_q <= w_nxt;
      end
    end

    assign words[g*DATA_W +: DATA_W] = w_q;
  end

endmodule

// File: rtl/mbx_cmd_queue.sv
module mbx_cmd_queue #(
  parameter int ENTRY_W = 544,
  parameter int DEPTH   = 4,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_data,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head,
  output logic [CNT_W-1:0]   count,
  output logic               full,
  output logic               empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr_q, wr_ptr_n, rd_ptr_q, rd_ptr_n;
  logic [CNT_W-1:0]   count_q, count_n;
  logic               do_push, do_pop;

  assign full  = (count_q == CNT_W'(DEPTH));
  assign empty = (count_q == '0);

  always_comb begin
    do_push  = push && !full;
    do_pop   = pop && !empty;
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    count_n  = count_q;
    if (do_push) begin
      wr_ptr_n = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end
    if (do_pop) begin
      rd_ptr_n = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({do_push, do_pop})
      2'b10:   count_n = count_q + 1'b1;
      2'b01:   count_n = count_q - 1'b1;
      default: count_n = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      count_q  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_ptr_q] <= push_data;
    end
  end

  assign head  = mem[rd_ptr_q];
  assign count = count_q;

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import cmd_mailbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_done,
  input  logic              set_drop,
  input  logic              set_full,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_data,
  input  logic              mask_en,
  input  logic [DATA_W-1:0] mask_data,
  output logic [DATA_W-1:0] cause_word,
  output logic [DATA_W-1:0] mask_word,
  output logic              irq
);

  localparam int NSRC = 3;

  logic [NSRC-1:0]   cause_q, cause_n, clr_vec, set_vec;
  logic [DATA_W-1:0] mask_q, mask_n;

  always_comb begin
    set_vec = {set_full, set_drop, set_done};
    clr_vec = '0;
    if (clr_en) begin
      clr_vec = {clr_data[CAUSE_FULL_BIT], clr_data[CAUSE_DROP_BIT],
                 clr_data[CAUSE_DONE_BIT]};
    end
    cause_n = (cause_q & ~clr_vec) | set_vec;
    mask_n  = mask_en ? mask_data : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '1;
    end else begin
      cause_q <= cause_n;
      mask_q  <= mask_n;
    end
  end

  always_comb begin
    cause_word                 = '0;
    cause_word[CAUSE_DONE_BIT] = cause_q[0];
    cause_word[CAUSE_DROP_BIT] = cause_q[1];
    cause_word[CAUSE_FULL_BIT] = cause_q[2];
  end

  assign mask_word = mask_q;
  assign irq       = |(cause_word & ~mask_q);

endmodule

// File: rtl/cmd_mailbox_top.sv
module cmd_mailbox_top
  import cmd_mailbox_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_WORDS   = 16,
  parameter int QUEUE_DEPTH = 4,
  parameter int ADDR_W      = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic                        cp_cmd_valid,
  output logic [DATA_W-1:0]           cp_cmd,
  output logic [NUM_WORDS*DATA_W-1:0] cp_params,
  input  logic                        cp_pop,
  input  logic [DATA_W-1:0]           cp_ret,
  input  logic [NUM_WORDS*DATA_W-1:0] cp_results,
  input  logic                        cp_done,
  output logic                        irq
);

  localparam int IDX_W   = $clog2(NUM_WORDS);
  localparam int CNT_W   = $clog2(QUEUE_DEPTH + 1);
  localparam int BANK_W  = NUM_WORDS * DATA_W;
  localparam int ENTRY_W = BANK_W + DATA_W;

  mbx_reg_e             region;
  logic [IDX_W-1:0]     sub_idx;
  logic [BANK_W-1:0]    param_words, result_words;
  logic [ENTRY_W-1:0]   q_head;
  logic [CNT_W-1:0]     q_count;
  logic                 q_full, q_empty;
  logic                 cmd_wr, push, drop, pop_acc, hit_full;
  logic                 done_q, done_n;
  logic [DATA_W-1:0]    ret_q, ret_n;
  logic [DATA_W-1:0]    cause_word, mask_word, status_word;

  mbx_addr_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_WORDS(NUM_WORDS),
    .IDX_W    (IDX_W)
  ) u_dec (
    .addr   (bus_addr),
    .region (region),
    .sub_idx(sub_idx)
  );

  mbx_word_bank #(
    .NUM_WORDS(NUM_WORDS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) u_args (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr && (region == REG_PARAM)),
    .wr_idx   (sub_idx),
    .wr_data  (bus_wdata),
    .load_en  (1'b0),
    .load_data('0),
    .words    (param_words)
  );

  mbx_word_bank #(
    .NUM_WORDS(NUM_WORDS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) u_results (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (1'b0),
    .wr_idx   ('0),
    .wr_data  ('0),
    .load_en  (cp_done),
    .load_data(cp_results),
    .words    (result_words)
  );

  always_comb begin
    cmd_wr   = bus_wr && (region == REG_CMD);
    push     = cmd_wr && !q_full;
    drop     = cmd_wr && q_full;
    pop_acc  = cp_pop && !q_empty;
    hit_full = push && !pop_acc && (q_count == CNT_W'(QUEUE_DEPTH - 1));
  end

  mbx_cmd_queue #(
    .ENTRY_W(ENTRY_W),
    .DEPTH  (QUEUE_DEPTH),
    .CNT_W  (CNT_W)
  ) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_data({bus_wdata, param_words}),
    .pop      (cp_pop),
    .head     (q_head),
    .count    (q_count),
    .full     (q_full),
    .empty    (q_empty)
  );

  always_comb begin
    done_n = cp_done;
    ret_n  = cp_done ? cp_ret : ret_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ret_q  <= '0;
    end else begin
      done_q <= done_n;
      ret_q  <= ret_n;
    end
  end

  mbx_irq_ctrl #(
    .DATA_W(DATA_W)
  ) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_done  (done_q),
    .set_drop  (drop),
    .set_full  (hit_full),
    .clr_en    (bus_wr && (region == REG_CAUSE)),
    .clr_data  (bus_wdata),
    .mask_en   (bus_wr && (region == REG_MASK)),
    .mask_data (bus_wdata),
    .cause_word(cause_word),
    .mask_word (mask_word),
    .irq       (irq)
  );

  always_comb begin
    status_word              = '0;
    status_word[READY_BIT]   = 1'b1;
    status_word[CNT_W-1:0]   = q_count;
  end

  always_comb begin
    case (region)
      REG_PARAM: bus_rdata = param_words[sub_idx*DATA_W +: DATA_W];
      REG_RET:   bus_rdata = ret_q;
      REG_RES:   bus_rdata = result_words[sub_idx*DATA_W +: DATA_W];
      REG_QSTAT: bus_rdata = status_word;
      REG_CAUSE: bus_rdata = cause_word;
      REG_MASK:  bus_rdata = mask_word;
      default:   bus_rdata = '0;
    endcase
  end

  assign cp_cmd_valid = !q_empty;
  assign cp_cmd       = q_head[ENTRY_W-1 -: DATA_W];
  assign cp_params    = q_head[BANK_W-1:0];

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import cmd_mailbox_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int NUM_WORDS   = 16,
  parameter int QUEUE_DEPTH = 4,
  parameter int CNT_W       = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              cp_pop,
  input logic              cp_done,
  input logic              cp_cmd_valid,
  input logic              irq,
  input logic [CNT_W-1:0]  q_count,
  input logic [DATA_W-1:0] cause_word,
  input logic [DATA_W-1:0] mask_word
);

  logic cmd_wr;
  assign cmd_wr = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(NUM_WORDS));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(QUEUE_DEPTH));

  assert_drop_sets_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && q_count == CNT_W'(QUEUE_DEPTH)) |=> cause_word[CAUSE_DROP_BIT]);

  assert_full_on_reach_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cp_pop && q_count == CNT_W'(QUEUE_DEPTH - 1))
      |=> (cause_word[CAUSE_FULL_BIT] && q_count == CNT_W'(QUEUE_DEPTH)));

  assert_done_to_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cp_done |-> ##2 cause_word[CAUSE_DONE_BIT]);

  assert_no_cause_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_word == '0) |-> !irq);

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_word[CAUSE_DONE_BIT] && mask_word[CAUSE_DROP_BIT] && mask_word[CAUSE_FULL_BIT])
      |-> !irq);

  assert_empty_pop_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_pop && !cp_cmd_valid && !cmd_wr) |=> $stable(q_count));

endmodule

bind cmd_mailbox_top mbx_checker #(
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .NUM_WORDS  (NUM_WORDS),
  .QUEUE_DEPTH(QUEUE_DEPTH),
  .CNT_W      (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .cp_pop      (cp_pop),
  .cp_done     (cp_done),
  .cp_cmd_valid(cp_cmd_valid),
  .irq         (irq),
  .q_count     (q_count),
  .cause_word  (cause_word),
  .mask_word   (mask_word)
);

// File: tb/sim_cmd_mailbox_top.sv
module sim_cmd_mailbox_top;

  localparam int DW = 32;
  localparam int NW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          cp_cmd_valid;
  logic [DW-1:0] cp_cmd;
  logic [NW*DW-1:0] cp_params;
  logic          cp_pop = 1'b0;
  logic [DW-1:0] cp_ret = '0;
  logic [NW*DW-1:0] cp_results = '0;
  logic          cp_done = 1'b0;
  logic          irq;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] rd;

  always #5 clk = ~clk;

  cmd_mailbox_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cp_cmd_valid(cp_cmd_valid),
    .cp_cmd(cp_cmd), .cp_params(cp_params), .cp_pop(cp_pop), .cp_ret(cp_ret),
    .cp_results(cp_results), .cp_done(cp_done), .irq(irq)
  );

  // {address, write data, expected read-back}
  localparam logic [71:0] VEC [0:7] = '{
    {8'h00, 32'hA5A50001, 32'hA5A50001},  // R2
    {8'h3C, 32'h5A5A000F, 32'h5A5A000F},  // R2
    {8'h20, 32'h12345678, 32'h12345678},  // R2
    {8'h80, 32'hDEADBEEF, 32'h00000000},  // R9
    {8'hC0, 32'hFFFFFFFF, 32'h00000000},  // R9
    {8'hC4, 32'h00000007, 32'h00000100},  // R9
    {8'hD0, 32'h11111111, 32'h00000000},  // R9
    {8'hFC, 32'h22222222, 32'h00000000}   // R9
  };

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pop_one();
    @(negedge clk);
    cp_pop = 1'b1;
    @(negedge clk);
    cp_pop = 1'b0;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(8'hC4, rd); check("R1 status", rd, 32'h100);
    bus_read(8'hC8, rd); check("R1 cause", rd, 32'h0);
    bus_read(8'hCC, rd); check("R1 mask", rd, 32'hFFFFFFFF);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 valid", {31'b0, cp_cmd_valid}, 32'h0);

    // table walk: R2 and R9
    for (int k = 0; k < 8; k++) begin
      bus_write(VEC[k][71:64], VEC[k][63:32]);
      bus_read(VEC[k][71:64], rd);
      check("R2/R9 table", rd, VEC[k][31:0]);
    end

    // R3 enqueue with snapshot
    for (int i = 0; i < NW; i++) bus_write(AW'(4*i), 32'h10000000 + DW'(i));
    bus_write(8'h40, 32'hC0DE0001);
    bus_read(8'h40, rd); check("R9 cmd reads zero", rd, 32'h0);
    bus_write(8'h00, 32'h20000000);
    bus_write(8'h40, 32'hC0DE0002);
    bus_read(8'hC4, rd); check("R3 count", rd, 32'h102);
    bus_write(8'h40, 32'hC0DE0003);
    bus_read(8'hC8, rd); check("R5 not yet full", rd, 32'h0);
    bus_write(8'h40, 32'hC0DE0004);
    bus_read(8'hC4, rd); check("R5 count 4", rd, 32'h104);
    bus_read(8'hC8, rd); check("R5 full cause", rd, 32'h00040000);
    bus_write(8'h40, 32'hC0DE0005);
    bus_read(8'hC4, rd); check("R4 dropped count", rd, 32'h104);
    bus_read(8'hC8, rd); check("R4 drop cause", rd, 32'h00060000);
    check("R8 masked irq", {31'b0, irq}, 32'h0);
    bus_write(8'hCC, 32'hFFFBFFFF);
    check("R8 unmasked irq", {31'b0, irq}, 32'h1);
    bus_write(8'hC8, 32'h00020000);
    bus_read(8'hC8, rd); check("R7 partial clear", rd, 32'h00040000);
    check("R8 irq stays", {31'b0, irq}, 32'h1);
    bus_write(8'hC8, 32'h00040000);
    bus_read(8'hC8, rd); check("R7 clear", rd, 32'h0);
    check("R8 irq drops", {31'b0, irq}, 32'h0);

    // R10 FIFO order at the coprocessor side
    check("R10 valid", {31'b0, cp_cmd_valid}, 32'h1);
    check("R10 head cmd", cp_cmd, 32'hC0DE0001);
    check("R3 snapshot arg0", cp_params[31:0], 32'h10000000);
    check("R3 snapshot arg15", cp_params[15*32 +: 32], 32'h1000000F);
    pop_one();
    check("R10 second cmd", cp_cmd, 32'hC0DE0002);
    check("R3 second arg0", cp_params[31:0], 32'h20000000);
    pop_one(); pop_one(); pop_one();
    bus_read(8'hC4, rd); check("R10 drained", rd, 32'h100);
    check("R10 valid low", {31'b0, cp_cmd_valid}, 32'h0);
    pop_one();
    bus_read(8'hC4, rd); check("R10 empty pop", rd, 32'h100);
    bus_write(8'h40, 32'hC0DE0006);
    check("R10 wrap head", cp_cmd, 32'hC0DE0006);
    pop_one();

    // R6 completion timing
    bus_write(8'hCC, 32'hFFFFFFFE);
    @(negedge clk);
    cp_ret = 32'hFACE0042;
    for (int j = 0; j < NW; j++) cp_results[j*32 +: 32] = 32'hAB000000 + DW'(j);
    cp_done = 1'b1;
    @(negedge clk);
    cp_done = 1'b0;
    bus_read(8'h80, rd); check("R6 ret", rd, 32'hFACE0042);
    bus_read(8'h84, rd); check("R6 result0", rd, 32'hAB000000);
    bus_read(8'hC0, rd); check("R6 result15", rd, 32'hAB00000F);
    bus_read(8'hC8, rd); check("R6 complete not yet", rd, 32'h0);
    @(negedge clk);
    bus_read(8'hC8, rd); check("R6 complete", rd, 32'h1);
    check("R8 done irq", {31'b0, irq}, 32'h1);
    bus_write(8'hC8, 32'h0);
    bus_read(8'hC8, rd); check("R7 zero write keeps", rd, 32'h1);
    bus_write(8'hC8, 32'h1);
    bus_read(8'hC8, rd); check("R7 done cleared", rd, 32'h0);
    check("R8 irq low", {31'b0, irq}, 32'h0);

    // R1 reset again mid-run
    bus_write(8'h40, 32'hC0DE0007);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(8'hC4, rd); check("R1 status after reset", rd, 32'h100);
    bus_read(8'hCC, rd); check("R1 mask after reset", rd, 32'hFFFFFFFF);
    bus_read(8'h00, rd); check("R1 arg cleared", rd, 32'h0);
    check("R1 valid after reset", {31'b0, cp_cmd_valid}, 32'h0);

    finish_run();
  end

endmodule